// File: doc/BRIEF.md
# Fully Associative Translation Lookup

This block translates a virtual page number into a physical page number by searching all entries of a small translation store at once. Every entry carries its own page size (eight choices from 1 KB to 16 MB), an optional 8-bit process tag, write and execute permission bits, and a 4-bit zone selector. A 32-bit zone register supplied with each lookup holds sixteen 2-bit zone codes. These codes can hide an entry from user-mode accesses, or raise the entry's rights for supervisor-only or for all accesses.

A lookup is issued by pulsing `req_i` with the page number, access type, privilege, current process ID and zone register. One cycle later the block reports, on registered outputs, exactly one of hit, protection error or miss. It also reports the winning index, physical page number, page size and effective write/execute rights. Entries are loaded through a one-entry-per-cycle write port. Page walking, fault handling and cache interaction stay with the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: The 3-bit size field s selects a page of 1 KB << (2·s): 0=1 KB, 1=4 KB, 2=16 KB, 3=64 KB, 4=256 KB, 5=1 MB, 6=4 MB, 7=16 MB. The entry's page number and the looked-up page number (virtual address bits 31:10) are compared only on bits at or above 2·s.
- R2: An entry with its valid bit clear never matches.
- R3: An entry whose process tag is zero matches any process. A nonzero tag matches only when it equals `pid_i`.
- R4: Zone code 0 hides the entry from user accesses (`user_i`=1), and the search goes on to higher indices. Supervisor accesses see the entry with its own rights.
- R5: Zone code 1 uses the entry's own write/execute bits. Code 2 forces write and execute on for supervisor accesses only. Code 3 forces them on for every access.
- R6: The code for zone z is `zpr_i[31-2z:30-2z]`. A zone selector greater than `NUM_ZONES` (default 12) acts as code 1.
- R7: Access type encodes 0 = read, 1 = write, 2 = fetch; 3 behaves as read. A read of a matched entry always hits. A write without effective write right, or a fetch without effective execute right, gives a protection error and no hit.
- R8: When several entries match, the lowest index decides the outcome, including when that outcome is a protection error.
- R9: On a miss, `miss_o` is 1 and the index, physical page, size and permission outputs are 0.
- R10: Results appear on the outputs one cycle after `req_i`, with `rsp_valid_o` high for that one cycle. The results hold unchanged until the next request.
- R11: A write through the write port affects lookups from the next cycle on. A lookup in the same cycle as a write sees the old contents.
- R12: After reset every entry is invalid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write an entry this cycle |
| wr_idx_i | input | 6 | Entry index to write |
| wr_valid_i | input | 1 | Valid bit for the written entry |
| wr_size_i | input | 3 | Page size code |
| wr_vpn_i | input | 22 | Virtual page number (1 KB units) |
| wr_tid_i | input | 8 | Process tag, 0 = any process |
| wr_ppn_i | input | 22 | Physical page number |
| wr_perm_w_i | input | 1 | Entry write right |
| wr_perm_x_i | input | 1 | Entry execute right |
| wr_zone_i | input | 4 | Zone selector |
| req_i | input | 1 | Lookup request |
| va_page_i | input | 22 | Virtual address bits 31:10 |
| acc_i | input | 2 | Access type |
| user_i | input | 1 | 1 = user mode, 0 = supervisor |
| pid_i | input | 8 | Current process ID |
| zpr_i | input | 32 | Zone code register |
| rsp_valid_o | output | 1 | Result strobe |
| hit_o | output | 1 | Translation granted |
| prot_err_o | output | 1 | Match found, access denied |
| miss_o | output | 1 | No matching entry |
| idx_o | output | 6 | Winning entry index |
| ppn_o | output | 22 | Winning physical page number |
| size_o | output | 3 | Winning page size code |
| perm_w_o | output | 1 | Effective write right |
| perm_x_o | output | 1 | Effective execute right |

## Verification
Directed lookups isolate single rules. Addresses lie just inside and just outside a 16 MB and a 4 KB page to separate size masking from exact compares. Matching and mismatching process IDs test the tag rule. Each zone code is tried under both privileges and all three access types, so a wrong code decode and a wrong privilege gate show as different failures. Two overlapping entries with different rights show whether the lowest index wins. The random phase fills the store from a narrow page pool so that multiple matches, wildcard tags and out-of-range zone selectors are frequent. It mixes in writes that coincide with lookups, which exposes a store that forwards new data early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PG_SH_MIN = 10;
  localparam int VPN_W     = VA_W - PG_SH_MIN;
  localparam int PPN_W     = 22;
  localparam int TID_W     = 8;
  localparam int SZ_W      = 3;
  localparam int ZSEL_W    = 4;
  localparam int ZPR_W     = 2 << ZSEL_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic              valid;
    logic [SZ_W-1:0]   size;
    logic [VPN_W-1:0]  vpn;
    logic [TID_W-1:0]  tid;
    logic [ZSEL_W-1:0] zone;
    logic              perm_w;
    logic              perm_x;
  } tlb_key_t;

  // page number bits that take part in the compare for a size code
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [SZ_W-1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    for (int j = 0; j < VPN_W; j++)
      if (j < 2 * int'(sz)) m[j] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  tlb_key_t         wr_key_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  output tlb_key_t         keys_o [N],
  output logic [PPN_W-1:0] ppns_o [N]
);
  tlb_key_t         keys_q [N];
  logic [PPN_W-1:0] ppns_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        keys_q[i] <= '0;
        ppns_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      keys_q[wr_idx_i] <= wr_key_i;
      ppns_q[wr_idx_i] <= wr_ppn_i;
    end
  end

  assign keys_o = keys_q;
  assign ppns_o = ppns_q;

  // R11: a written entry is visible on the next cycle
  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (keys_o[$past(wr_idx_i)] == $past(wr_key_i)) &&
                (ppns_o[$past(wr_idx_i)] == $past(wr_ppn_i)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N         = 64,
  parameter int NUM_ZONES = 12,
  parameter bit ZONES_EN  = 1'b1
) (
  input  tlb_key_t         keys_i [N],
  input  logic [VPN_W-1:0] va_page_i,
  input  logic             user_i,
  input  logic [TID_W-1:0] pid_i,
  input  logic [ZPR_W-1:0] zpr_i,
  output logic [N-1:0]     match_o,
  output logic [N-1:0]     eff_w_o,
  output logic [N-1:0]     eff_x_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic       addr_hit, tid_hit, hidden;
    logic [1:0] zcode;

    assign addr_hit = keys_i[g].valid &&
                      (((va_page_i ^ keys_i[g].vpn) & vpn_mask(keys_i[g].size)) == '0);
    assign tid_hit  = (keys_i[g].tid == '0) || (keys_i[g].tid == pid_i);

    if (ZONES_EN) begin : g_zone
      logic [ZPR_W-1:0] zsh;
      assign zsh = zpr_i >> (ZPR_W - 2 - 2 * int'(keys_i[g].zone));
      assign zcode = (int'(keys_i[g].zone) > NUM_ZONES) ? 2'd1 : zsh[1:0];
    end else begin : g_nozone
      assign zcode = 2'd1;
    end

    assign hidden     = (zcode == 2'd0) && user_i;
    assign match_o[g] = addr_hit && tid_hit && !hidden;
    assign eff_w_o[g] = keys_i[g].perm_w || (zcode == 2'd3) || ((zcode == 2'd2) && !user_i);
    assign eff_x_o[g] = keys_i[g].perm_x || (zcode == 2'd3) || ((zcode == 2'd2) && !user_i);
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest set bit is the last assignment
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int NUM_ZONES = 12,
  parameter bit ZONES_EN  = 1'b1,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [SZ_W-1:0]   wr_size_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [TID_W-1:0]  wr_tid_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic              wr_perm_w_i,
  input  logic              wr_perm_x_i,
  input  logic [ZSEL_W-1:0] wr_zone_i,
  input  logic              req_i,
  input  logic [VPN_W-1:0]  va_page_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic [TID_W-1:0]  pid_i,
  input  logic [ZPR_W-1:0]  zpr_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              prot_err_o,
  output logic              miss_o,
  output logic [IW-1:0]     idx_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [SZ_W-1:0]   size_o,
  output logic              perm_w_o,
  output logic              perm_x_o
);
  tlb_key_t         wr_key;
  tlb_key_t         keys [N_ENTRIES];
  logic [PPN_W-1:0] ppns [N_ENTRIES];
  logic [N_ENTRIES-1:0] match_v, eff_w_v, eff_x_v;
  logic                 any_m;
  logic [IW-1:0]        win_idx;
  logic                 w_ok, x_ok, deny;

  always_comb begin
    wr_key.valid  = wr_valid_i;
    wr_key.size   = wr_size_i;
    wr_key.vpn    = wr_vpn_i;
    wr_key.tid    = wr_tid_i;
    wr_key.zone   = wr_zone_i;
    wr_key.perm_w = wr_perm_w_i;
    wr_key.perm_x = wr_perm_x_i;
  end

  tlb_store #(.N(N_ENTRIES)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_key_i (wr_key),
    .wr_ppn_i (wr_ppn_i),
    .keys_o   (keys),
    .ppns_o   (ppns)
  );

  tlb_match #(.N(N_ENTRIES), .NUM_ZONES(NUM_ZONES), .ZONES_EN(ZONES_EN)) u_match (
    .keys_i    (keys),
    .va_page_i (va_page_i),
    .user_i    (user_i),
    .pid_i     (pid_i),
    .zpr_i     (zpr_i),
    .match_o   (match_v),
    .eff_w_o   (eff_w_v),
    .eff_x_o   (eff_x_v)
  );

  tlb_prio #(.N(N_ENTRIES)) u_prio (
    .req_i (match_v),
    .any_o (any_m),
    .idx_o (win_idx)
  );

  assign w_ok = eff_w_v[win_idx];
  assign x_ok = eff_x_v[win_idx];
  assign deny = ((acc_i == ACC_WRITE) && !w_ok) || ((acc_i == ACC_FETCH) && !x_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      prot_err_o  <= 1'b0;
      miss_o      <= 1'b0;
      idx_o       <= '0;
      ppn_o       <= '0;
      size_o      <= '0;
      perm_w_o    <= 1'b0;
      perm_x_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        hit_o      <= any_m && !deny;
        prot_err_o <= any_m && deny;
        miss_o     <= !any_m;
        idx_o      <= any_m ? win_idx : '0;
        ppn_o      <= any_m ? ppns[win_idx] : '0;
        size_o     <= any_m ? keys[win_idx].size : '0;
        perm_w_o   <= any_m && w_ok;
        perm_x_o   <= any_m && x_ok;
      end
    end
  end

  // R8: the chosen entry matches and no lower entry does
  logic [N_ENTRIES-1:0] one_v, below_v;
  assign one_v   = N_ENTRIES'(1);
  assign below_v = (one_v << win_idx) - one_v;

  a_r8_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_m |-> match_v[win_idx] && ((match_v & below_v) == '0));

  a_r8_none_means_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_m |-> (match_v == '0));

  a_r10_strobe_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  a_r10_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(hit_o) && $stable(prot_err_o) && $stable(miss_o) && $stable(idx_o));

  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({hit_o, prot_err_o, miss_o}) == 1);

  a_r7_hit_has_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && any_m && !deny) |=> !((acc_i == ACC_WRITE) && !perm_w_o) || 1'b1 ? 
      (hit_o && !(($past(acc_i) == ACC_WRITE) && !perm_w_o) && !(($past(acc_i) == ACC_FETCH) && !perm_x_o)) : 1'b0);

  a_r7_err_lacks_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && prot_err_o) |->
      ((($past(acc_i) == ACC_WRITE) && !perm_w_o) || (($past(acc_i) == ACC_FETCH) && !perm_x_o)));

  a_r9_miss_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (idx_o == '0) && (ppn_o == '0) && (size_o == '0) && !perm_w_o && !perm_x_o);
endmodule

// File: tb/tlb_lookup_tb.sv
module tlb_lookup_tb;
  localparam int N = 64;
  localparam int NZ = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic        wr_valid = 0;
  logic [2:0]  wr_size = 0;
  logic [21:0] wr_vpn = 0;
  logic [7:0]  wr_tid = 0;
  logic [21:0] wr_ppn = 0;
  logic        wr_w = 0, wr_x = 0;
  logic [3:0]  wr_zone = 0;
  logic        req = 0;
  logic [21:0] va_page = 0;
  logic [1:0]  acc = 0;
  logic        user = 0;
  logic [7:0]  pid = 0;
  logic [31:0] zpr = 0;
  logic        rsp_valid, hit, perr, miss, pw, px;
  logic [5:0]  idx;
  logic [21:0] ppn;
  logic [2:0]  size;

  tlb_lookup #(.N_ENTRIES(N), .NUM_ZONES(NZ), .ZONES_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_size_i(wr_size),
    .wr_vpn_i(wr_vpn), .wr_tid_i(wr_tid), .wr_ppn_i(wr_ppn), .wr_perm_w_i(wr_w),
    .wr_perm_x_i(wr_x), .wr_zone_i(wr_zone),
    .req_i(req), .va_page_i(va_page), .acc_i(acc), .user_i(user), .pid_i(pid), .zpr_i(zpr),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .prot_err_o(perr), .miss_o(miss), .idx_o(idx),
    .ppn_o(ppn), .size_o(size), .perm_w_o(pw), .perm_x_o(px)
  );

  // bench copy of what was written
  logic        m_valid [N];
  logic [2:0]  m_size  [N];
  logic [21:0] m_vpn   [N];
  logic [7:0]  m_tid   [N];
  logic [21:0] m_ppn   [N];
  logic        m_w [N], m_x [N];
  logic [3:0]  m_zone  [N];

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [35:0] act_vec();
    return {hit, perr, miss, idx, ppn, size, pw, px};
  endfunction

  function automatic logic [35:0] expect_lookup(logic [21:0] vp, logic [1:0] a, logic u,
                                                logic [7:0] p, logic [31:0] z);
    for (int i = 0; i < N; i++) begin
      int sh;
      logic [1:0] code;
      logic w, x, bad;
      if (!m_valid[i]) continue;
      sh = 2 * int'(m_size[i]);
      if ((vp >> sh) != (m_vpn[i] >> sh)) continue;
      if (m_tid[i] != 8'd0 && m_tid[i] != p) continue;
      if (int'(m_zone[i]) > NZ) code = 2'd1;
      else code = 2'(z >> (30 - 2 * int'(m_zone[i])));
      if (code == 2'd0 && u) continue;
      w = m_w[i] | (code == 2'd3) | (code == 2'd2 && !u);
      x = m_x[i] | (code == 2'd3) | (code == 2'd2 && !u);
      bad = (a == 2'd1 && !w) || (a == 2'd2 && !x);
      return {!bad, bad, 1'b0, 6'(i), m_ppn[i], m_size[i], w, x};
    end
    return {3'b001, 33'd0};
  endfunction

  task automatic chk(string tag, logic [35:0] a, logic [35:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, a, e);
    end
  endtask

  task automatic chk_bit(string tag, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, a, e);
    end
  endtask

  task automatic model_put(int i, logic v, logic [2:0] s, logic [21:0] vp, logic [7:0] t,
                           logic [21:0] pp, logic w, logic x, logic [3:0] zn);
    m_valid[i] = v; m_size[i] = s; m_vpn[i] = vp; m_tid[i] = t;
    m_ppn[i] = pp; m_w[i] = w; m_x[i] = x; m_zone[i] = zn;
  endtask

  task automatic drive_wr(int i, logic v, logic [2:0] s, logic [21:0] vp, logic [7:0] t,
                          logic [21:0] pp, logic w, logic x, logic [3:0] zn);
    wr_en = 1; wr_idx = 6'(i); wr_valid = v; wr_size = s; wr_vpn = vp; wr_tid = t;
    wr_ppn = pp; wr_w = w; wr_x = x; wr_zone = zn;
  endtask

  task automatic put(int i, logic v, logic [2:0] s, logic [21:0] vp, logic [7:0] t,
                     logic [21:0] pp, logic w, logic x, logic [3:0] zn);
    drive_wr(i, v, s, vp, t, pp, w, x, zn);
    @(posedge clk);
    model_put(i, v, s, vp, t, pp, w, x, zn);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(string tag, logic [21:0] vp, logic [1:0] a, logic u,
                      logic [7:0] p, logic [31:0] z);
    logic [35:0] e;
    e = expect_lookup(vp, a, u, p, z);
    req = 1; va_page = vp; acc = a; user = u; pid = p; zpr = z;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    chk_bit({tag, " R10 strobe"}, rsp_valid, 1'b1);
    chk(tag, act_vec(), e);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R10 strobe drop", rsp_valid, 1'b0);
    chk("R10 hold", act_vec(), e);
  endtask

  // R11: lookup and write in the same cycle; lookup sees old contents
  task automatic look_with_write(logic [21:0] vp, logic [1:0] a, logic u, logic [7:0] p,
                                 logic [31:0] z, int i, logic v, logic [2:0] s,
                                 logic [21:0] wvp, logic [7:0] t, logic [21:0] pp,
                                 logic w, logic x, logic [3:0] zn);
    logic [35:0] e;
    e = expect_lookup(vp, a, u, p, z);
    drive_wr(i, v, s, wvp, t, pp, w, x, zn);
    req = 1; va_page = vp; acc = a; user = u; pid = p; zpr = z;
    @(posedge clk);
    model_put(i, v, s, wvp, t, pp, w, x, zn);
    @(negedge clk);
    req = 0; wr_en = 0;
    chk("R11 same-cycle write", act_vec(), e);
  endtask

  function automatic logic [21:0] rnd_page();
    return 22'($urandom) & 22'h000C03;
  endfunction

  function automatic logic [7:0] rnd_tid();
    case ($urandom % 4)
      0: return 8'h00;
      1: return 8'h11;
      2: return 8'h22;
      default: return 8'h33;
    endcase
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) model_put(i, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", act_vec(), 36'd0);
    chk_bit("R12 reset strobe", rsp_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    look("R12 empty store misses", 22'h00100, 2'd0, 1'b0, 8'h00, 32'h0);

    // zone behaviour on entry 5, zone 0
    put(5, 1, 3'd0, 22'h00100, 8'h00, 22'h2AAAA, 0, 0, 4'd0);
    look("R4 supervisor sees code0", 22'h00100, 2'd0, 1'b0, 8'h00, 32'h0);
    look("R4 user hidden by code0", 22'h00100, 2'd0, 1'b1, 8'h00, 32'h0);
    look("R7 supervisor write no right", 22'h00100, 2'd1, 1'b0, 8'h00, 32'h0);
    look("R5 code2 supervisor write", 22'h00100, 2'd1, 1'b0, 8'h00, 32'h8000_0000);
    look("R5 code2 user write", 22'h00100, 2'd1, 1'b1, 8'h00, 32'h8000_0000);
    look("R5 code3 user fetch", 22'h00100, 2'd2, 1'b1, 8'h00, 32'hC000_0000);
    look("R5 code1 user fetch", 22'h00100, 2'd2, 1'b1, 8'h00, 32'h4000_0000);
    look("R7 code1 user read", 22'h00100, 2'd0, 1'b1, 8'h00, 32'h4000_0000);
    look("R7 access 3 as read", 22'h00100, 2'd3, 1'b1, 8'h00, 32'h4000_0000);

    // sizes
    put(8, 1, 3'd7, 22'h3C000, 8'h00, 22'h01234, 1, 1, 4'd1);
    look("R1 16MB inside", 22'h3FFFF, 2'd0, 1'b0, 8'h00, 32'h0);
    look("R1 16MB outside", 22'h40000, 2'd0, 1'b0, 8'h00, 32'h0);
    put(9, 1, 3'd1, 22'h00204, 8'h00, 22'h00777, 1, 0, 4'd1);
    look("R1 4KB inside", 22'h00207, 2'd0, 1'b0, 8'h00, 32'h0);
    look("R1 4KB outside", 22'h00208, 2'd0, 1'b0, 8'h00, 32'h0);

    // process tag
    put(12, 1, 3'd0, 22'h00500, 8'h5A, 22'h00042, 0, 1, 4'd1);
    look("R3 tag equal", 22'h00500, 2'd2, 1'b1, 8'h5A, 32'h1000_0000);
    look("R3 tag differs", 22'h00500, 2'd2, 1'b1, 8'h5B, 32'h1000_0000);

    // zone selector range and field position
    put(13, 1, 3'd0, 22'h00600, 8'h00, 22'h00013, 1, 0, 4'd14);
    look("R6 selector above range user read", 22'h00600, 2'd0, 1'b1, 8'h00, 32'h0);
    look("R6 selector above range user write", 22'h00600, 2'd1, 1'b1, 8'h00, 32'h0);
    put(14, 1, 3'd0, 22'h00700, 8'h00, 22'h00014, 0, 0, 4'd12);
    look("R6 zone12 code0 user", 22'h00700, 2'd0, 1'b1, 8'h00, 32'h0);
    look("R6 zone12 code3 user fetch", 22'h00700, 2'd2, 1'b1, 8'h00, 32'h0000_00C0);

    // priority
    put(10, 1, 3'd0, 22'h00800, 8'h00, 22'h00010, 1, 1, 4'd1);
    put(3, 1, 3'd0, 22'h00800, 8'h00, 22'h00003, 0, 0, 4'd1);
    look("R8 lowest index denies", 22'h00800, 2'd1, 1'b0, 8'h00, 32'h1000_0000);
    put(3, 0, 3'd0, 22'h00800, 8'h00, 22'h00003, 0, 0, 4'd1);
    look("R2 invalid entry skipped", 22'h00800, 2'd1, 1'b0, 8'h00, 32'h1000_0000);

    // write and lookup in the same cycle
    look_with_write(22'h00900, 2'd0, 1'b0, 8'h00, 32'h0,
                    20, 1, 3'd0, 22'h00900, 8'h00, 22'h00020, 1, 1, 4'd1);
    look("R11 write visible next", 22'h00900, 2'd0, 1'b0, 8'h00, 32'h0);
    look("R9 miss fields zero", 22'h3FFFF & 22'h00C03, 2'd1, 1'b1, 8'h77, 32'h0);

    // random phase
    for (int i = 0; i < N; i++)
      put(i, ($urandom % 4) != 0, 3'($urandom % 8), rnd_page(), rnd_tid(),
          22'($urandom), 1'($urandom), 1'($urandom), 4'($urandom % 16));
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom % 10;
      if (sel == 0)
        put($urandom % N, ($urandom % 4) != 0, 3'($urandom % 8), rnd_page(), rnd_tid(),
            22'($urandom), 1'($urandom), 1'($urandom), 4'($urandom % 16));
      else if (sel == 1)
        look_with_write(rnd_page(), 2'($urandom), 1'($urandom), rnd_tid(), $urandom,
                        $urandom % N, ($urandom % 4) != 0, 3'($urandom % 8), rnd_page(),
                        rnd_tid(), 22'($urandom), 1'($urandom), 1'($urandom),
                        4'($urandom % 16));
      else
        look("R1 R3 R5 R7 R8 random", rnd_page(), 2'($urandom), 1'($urandom), rnd_tid(),
             $urandom);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule